// File: doc/BRIEF.md
# Configurable Byte-Stream DMA Port

This block connects a 16-bit external DMA data bus to an 8-bit internal byte stream through a small byte FIFO. A direction input picks the flow. When inbound, words taken from the bus enter the FIFO and leave on the stream output. When outbound, stream bytes enter the FIFO and are placed on the bus. Every bus transfer moves either one byte (low lane only) or two bytes, with the low lane first in stream order. Each byte lane carries an odd parity bit. The port generates parity on outgoing words and checks it on incoming ones. A mismatch raises a sticky error flag.

Transfers on the bus use a request/acknowledge handshake. As master, the port raises a request and waits for an acknowledge. As slave, it answers an external request with an acknowledge and a one-cycle read or write strobe. A programmable number of wait cycles separates the acceptance of the handshake from the cycle that moves data. Two programmable thresholds produce almost-empty and almost-full flags. Every control pin has its own polarity bit. Settings are written over a small register port: address 0 holds the polarity, address 1 the almost-empty threshold, address 2 the almost-full threshold, and address 3 the control byte.

Both stream sides use valid/ready. The output side keeps `m_valid` high while the FIFO holds a byte and the port is inbound, and it holds `m_data` until `m_ready` takes it. The input side raises `s_ready` only when the port is outbound and the FIFO has a free byte, so a full FIFO back-pressures the producer. The direction input and the control byte should be changed only while no handshake is in progress and the FIFO is empty. DEPTH must be a power of two.

Top module: `dma_port`

## Requirements
- R1: With `inbound`=1, bus data flows into the FIFO and out on `m_*`, and `s_ready` stays 0. With `inbound`=0, stream bytes flow out to the bus, `m_valid` stays 0, and `bus_oe` is 1 only in wait and transfer cycles.
- R2: The FIFO holds DEPTH bytes and keeps their order. `m_valid` is 1 while it is non-empty (inbound), `s_ready` is 1 while it is not full (outbound), and the bus side never moves more bytes than the FIFO holds or has room for.
- R3: Outgoing parity is odd. `bus_pout[0]` makes `bus_dout[7:0]` plus that bit have an odd count of ones, and `bus_pout[1]` does the same for lane 1. In 8-bit mode, `bus_dout[15:8]` and `bus_pout[1]` are 0.
- R4: An inbound transfer whose used lanes fail odd parity sets `par_err`. The flag stays set until a write to address 3 clears it, and a new error in the same cycle wins. In 8-bit mode lane 1 is not checked.
- R5: `ae_o` (logical) is 1 when the byte count is at most the address 1 value. `af_o` (logical) is 1 when the count is at least the address 2 value.
- R6: Each control pin equals its logical level XOR a bit of the address 0 register. Bit 7 maps to `ctl_in`, bit 5 to `ctl_out`, bit 4 to `wr_o`, bit 3 to `rd_o`, bit 2 to `cs_o`, bit 1 to `af_o` and bit 0 to `ae_o`.
- R7: In master mode (control bit 0 = 0), `ctl_in` is the acknowledge and `ctl_out` the request. The request rises in idle only when the FIFO can take (inbound) or supply (outbound) a full transfer. It stays high through the wait and transfer cycles and drops afterwards. `wr_o` and `rd_o` stay deasserted.
- R8: In slave mode (bit 0 = 1), `ctl_in` is the request and `ctl_out` the acknowledge. The acknowledge rises in the transfer cycle and holds until the request drops. The transfer cycle carries a one-cycle `rd_o` (inbound) or `wr_o` (outbound) strobe.
- R9: Control bit 1 selects 16-bit transfers (two bytes, low lane first in stream order). When clear, transfers are 8-bit and use the low lane only.
- R10: Control bits 7:4 give the wait count W. After the handshake is accepted, exactly W cycles pass before the single transfer cycle.
- R11: `cs_o` (logical) is 1 from the cycle after acceptance until the handshake returns to idle.
- R12: After reset, the polarity register is 0, the thresholds are 2 and DEPTH-2, and the port is in master mode with 8-bit transfers and no wait cycles. The FIFO is empty and `par_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 8 | Register write data |
| inbound | input | 1 | 1: bus to stream, 0: stream to bus |
| s_data | input | 8 | Stream input byte |
| s_valid | input | 1 | Stream input valid |
| s_ready | output | 1 | Stream input ready |
| m_data | output | 8 | Stream output byte |
| m_valid | output | 1 | Stream output valid |
| m_ready | input | 1 | Stream output ready |
| bus_din | input | 16 | Bus data sampled when inbound |
| bus_pin | input | 2 | Bus parity sampled when inbound |
| bus_dout | output | 16 | Bus data driven when outbound |
| bus_pout | output | 2 | Bus parity driven when outbound |
| bus_oe | output | 1 | Bus output enable |
| ctl_in | input | 1 | Handshake input (acknowledge or request) |
| ctl_out | output | 1 | Handshake output (request or acknowledge) |
| wr_o | output | 1 | Write strobe (slave, outbound) |
| rd_o | output | 1 | Read strobe (slave, inbound) |
| cs_o | output | 1 | Handshake active |
| af_o | output | 1 | Almost full |
| ae_o | output | 1 | Almost empty |
| par_err | output | 1 | Sticky parity error |

## Verification
The bench builds the block with its defaults, a 16-byte FIFO and a 4-bit wait field. At that size random stream back-pressure fills and empties the FIFO many times, so the full-FIFO request hold-off and both threshold flags are reached often. The 4-bit wait field covers wait counts of 0, 1, 2, 3 and 5, and the wait-count measurement is made at 0 and 5. The runs cover both directions in both handshake roles, 8-bit and 16-bit transfers, parity faults on either lane, and an all-inverted polarity setting.

// File: rtl/dma_port_pkg.sv
package dma_port_pkg;
  typedef enum logic [1:0] {HS_IDLE, HS_WAIT, HS_XFER, HS_HOLD} hs_state_e;

  localparam int POL_AE = 0;
  localparam int POL_AF = 1;
  localparam int POL_CS = 2;
  localparam int POL_RD = 3;
  localparam int POL_WR = 4;
  localparam int POL_CO = 5;
  localparam int POL_CI = 7;

  function automatic logic odd_par(input logic [7:0] b);
    return ~(^b);
  endfunction
endpackage

// File: rtl/dma_port_cfg.sv
module dma_port_cfg #(
  parameter int DEPTH  = 16,
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        pol,
  output logic [7:0]        ae_thr,
  output logic [7:0]        af_thr,
  output logic              slave,
  output logic              wide,
  output logic [WAIT_W-1:0] waits,
  output logic              clr_err
);
  localparam logic [7:0] AE_RST = 8'd2;
  localparam logic [7:0] AF_RST = 8'(DEPTH - 2);
  localparam int WAIT_LSB = 4;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pol    <= '0;
      ae_thr <= AE_RST;
      af_thr <= AF_RST;
      slave  <= 1'b0;
      wide   <= 1'b0;
      waits  <= '0;
    end else if (we) begin
      case (addr)
        2'd0: pol    <= wdata;
        2'd1: ae_thr <= wdata;
        2'd2: af_thr <= wdata;
        default: begin
          slave <= wdata[0];
          wide  <= wdata[1];
          waits <= wdata[WAIT_LSB +: WAIT_W];
        end
      endcase
    end
  end

  assign clr_err = we && (addr == 2'd3);
endmodule

// File: rtl/dma_port_fifo.sv
module dma_port_fifo #(
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [1:0]                   push_n,
  input  logic [15:0]                  push_d,
  input  logic [1:0]                   pop_n,
  output logic [15:0]                  head,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wptr, rptr;

  always_ff @(posedge clk) begin
    if (push_n != 2'd0) mem[wptr] <= push_d[7:0];
    if (push_n == 2'd2) mem[wptr + AW'(1)] <= push_d[15:8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      wptr  <= wptr + AW'(push_n);
      rptr  <= rptr + AW'(pop_n);
      count <= count + CW'(push_n) - CW'(pop_n);
    end
  end

  assign head = {mem[rptr + AW'(1)], mem[rptr]};

  // R2: never more bytes than the storage holds
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(count) + int'(push_n) - int'(pop_n)) <= DEPTH);
  // R2: never take bytes that are not there
  p_no_underflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pop_n) <= int'(count));
endmodule

// File: rtl/dma_port_hs.sv
module dma_port_hs
  import dma_port_pkg::*;
#(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slave,
  input  logic              inbound,
  input  logic [WAIT_W-1:0] waits,
  input  logic              able,
  input  logic              hs_in,
  output logic              xfer,
  output logic              drive,
  output logic              co_l,
  output logic              wr_l,
  output logic              rd_l,
  output logic              cs_l
);
  hs_state_e         st;
  logic [WAIT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= HS_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        HS_IDLE: if (able && hs_in) begin
          cnt <= waits;
          st  <= (waits == '0) ? HS_XFER : HS_WAIT;
        end
        HS_WAIT: begin
          cnt <= cnt - WAIT_W'(1);
          if (cnt == WAIT_W'(1)) st <= HS_XFER;
        end
        HS_XFER: st <= HS_HOLD;
        default: if (!hs_in) st <= HS_IDLE;
      endcase
    end
  end

  assign xfer  = (st == HS_XFER);
  assign drive = (st == HS_WAIT) || (st == HS_XFER);
  assign cs_l  = (st != HS_IDLE);
  assign co_l  = slave ? (st == HS_XFER || st == HS_HOLD)
                       : ((st == HS_IDLE && able) || drive);
  assign wr_l  = slave && xfer && !inbound;
  assign rd_l  = slave && xfer && inbound;

  // R10: last wait cycle leads into the transfer cycle
  p_wait_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == HS_WAIT && cnt == WAIT_W'(1)) |=> (st == HS_XFER));
  // R8: the transfer lasts one cycle and then holds
  p_xfer_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == HS_XFER) |=> (st == HS_HOLD));
  // R8: hold persists while the partner keeps its strobe
  p_hold_until_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == HS_HOLD && hs_in) |=> (st == HS_HOLD));
endmodule

// File: rtl/dma_port.sv
module dma_port
  import dma_port_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int WAIT_W = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_addr,
  input  logic [7:0]  cfg_wdata,
  input  logic        inbound,
  input  logic [7:0]  s_data,
  input  logic        s_valid,
  output logic        s_ready,
  output logic [7:0]  m_data,
  output logic        m_valid,
  input  logic        m_ready,
  input  logic [15:0] bus_din,
  input  logic [1:0]  bus_pin,
  output logic [15:0] bus_dout,
  output logic [1:0]  bus_pout,
  output logic        bus_oe,
  input  logic        ctl_in,
  output logic        ctl_out,
  output logic        wr_o,
  output logic        rd_o,
  output logic        cs_o,
  output logic        af_o,
  output logic        ae_o,
  output logic        par_err
);
  localparam int CW = $clog2(DEPTH+1);

  logic [7:0]        pol, ae_thr, af_thr;
  logic              slave, wide, clr_err;
  logic [WAIT_W-1:0] waits;
  logic [CW-1:0]     count;
  logic [15:0]       head;
  logic [1:0]        push_n, pop_n, nb;
  logic [15:0]       push_d;
  logic              able, hs_in, xfer, drive, co_l, wr_l, rd_l, cs_l;
  logic              bad_par;
  int                free_b;

  dma_port_cfg #(.DEPTH(DEPTH), .WAIT_W(WAIT_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .pol(pol), .ae_thr(ae_thr), .af_thr(af_thr), .slave(slave), .wide(wide),
    .waits(waits), .clr_err(clr_err)
  );

  dma_port_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push_n(push_n), .push_d(push_d),
    .pop_n(pop_n), .head(head), .count(count)
  );

  assign nb     = wide ? 2'd2 : 2'd1;
  assign free_b = DEPTH - int'(count);
  assign able   = inbound ? (free_b >= int'(nb)) : (int'(count) >= int'(nb));
  assign hs_in  = ctl_in ^ pol[POL_CI];

  dma_port_hs #(.WAIT_W(WAIT_W)) u_hs (
    .clk(clk), .rst_n(rst_n), .slave(slave), .inbound(inbound), .waits(waits),
    .able(able), .hs_in(hs_in), .xfer(xfer), .drive(drive), .co_l(co_l),
    .wr_l(wr_l), .rd_l(rd_l), .cs_l(cs_l)
  );

  // stream side
  assign m_valid = inbound && (count != '0);
  assign m_data  = head[7:0];
  assign s_ready = !inbound && (int'(count) < DEPTH);

  always_comb begin
    if (inbound) begin
      push_n = xfer ? nb : 2'd0;
      push_d = bus_din;
      pop_n  = (m_valid && m_ready) ? 2'd1 : 2'd0;
    end else begin
      push_n = (s_valid && s_ready) ? 2'd1 : 2'd0;
      push_d = {8'h00, s_data};
      pop_n  = xfer ? nb : 2'd0;
    end
  end

  // bus side
  assign bus_oe   = !inbound && drive;
  assign bus_dout = wide ? head : {8'h00, head[7:0]};
  assign bus_pout = {wide ? odd_par(head[15:8]) : 1'b0, odd_par(head[7:0])};

  assign bad_par = (bus_pin[0] != odd_par(bus_din[7:0])) ||
                   (wide && (bus_pin[1] != odd_par(bus_din[15:8])));

  always_ff @(posedge clk) begin
    if (!rst_n)                        par_err <= 1'b0;
    else if (xfer && inbound && bad_par) par_err <= 1'b1;
    else if (clr_err)                  par_err <= 1'b0;
  end

  // pins with polarity
  assign ctl_out = co_l ^ pol[POL_CO];
  assign wr_o    = wr_l ^ pol[POL_WR];
  assign rd_o    = rd_l ^ pol[POL_RD];
  assign cs_o    = cs_l ^ pol[POL_CS];
  assign af_o    = (int'(count) >= int'(af_thr)) ^ pol[POL_AF];
  assign ae_o    = (int'(count) <= int'(ae_thr)) ^ pol[POL_AE];

  // R4: error flag is sticky until cleared
  p_perr_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (par_err && !clr_err) |=> par_err);
  // R2: an inbound transfer always finds room
  p_xfer_room_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && inbound) |-> (free_b >= int'(nb)));
  // R2: an outbound transfer always finds data
  p_xfer_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !inbound) |-> (int'(count) >= int'(nb)));
endmodule

// File: tb/dma_port_bench.sv
module dma_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SAMPLE_DLY = 3;
  localparam int DEPTH = 16;
  localparam int WAIT_W = 4;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0; logic [1:0] cfg_addr = 0; logic [7:0] cfg_wdata = 0;
  logic inbound = 1;
  logic [7:0] s_data = 0; logic s_valid = 0; logic s_ready;
  logic [7:0] m_data; logic m_valid; logic m_ready = 0;
  logic [15:0] bus_din = 0; logic [1:0] bus_pin = 0;
  logic [15:0] bus_dout; logic [1:0] bus_pout; logic bus_oe;
  logic ctl_in, ctl_out, wr_o, rd_o, cs_o, af_o, ae_o, par_err;

  int total = 0, bad = 0;
  bit chk_on = 0;
  int s_prob = 0, mr_prob = 0, inj_prob = 0;
  bit inj_hi_only = 0;
  bit partner_on = 0;
  bit hs_lvl = 0;
  logic [7:0] b_pol = 0; bit b_slave = 0, b_wide = 0;

  // model state
  int m_st = 0, m_cnt = 0;
  logic [7:0] q[$];
  bit m_perr = 0, m_slave = 0, m_wide = 0;
  logic [7:0] m_pol = 0; int m_ae = 2, m_af = DEPTH - 2, m_waits = 0;

  dma_port u_dma_port (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .inbound(inbound), .s_data(s_data),
    .s_valid(s_valid), .s_ready(s_ready), .m_data(m_data), .m_valid(m_valid),
    .m_ready(m_ready), .bus_din(bus_din), .bus_pin(bus_pin),
    .bus_dout(bus_dout), .bus_pout(bus_pout), .bus_oe(bus_oe),
    .ctl_in(ctl_in), .ctl_out(ctl_out), .wr_o(wr_o), .rd_o(rd_o),
    .cs_o(cs_o), .af_o(af_o), .ae_o(ae_o), .par_err(par_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  assign ctl_in = hs_lvl ^ b_pol[7];

  function automatic logic op(input logic [7:0] b);
    return ~(^b);
  endfunction

  task automatic chk(input bit ok, input string rq, input string nm,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", rq, nm, act, exp, $time);
    end
  endtask

  // reference model update
  always @(posedge clk) begin : mdl
    int nb; bit able, hs_in, xf, err;
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; q.delete(); m_perr = 0; m_pol = 0;
      m_ae = 2; m_af = DEPTH - 2; m_slave = 0; m_wide = 0; m_waits = 0;
    end else begin
      nb = m_wide ? 2 : 1;
      able = inbound ? (DEPTH - q.size() >= nb) : (q.size() >= nb);
      hs_in = ctl_in ^ m_pol[7];
      xf = (m_st == 2);
      err = 0;
      if (inbound) begin
        if (q.size() > 0 && m_ready) void'(q.pop_front());
        if (xf) begin
          q.push_back(bus_din[7:0]);
          if (bus_pin[0] != op(bus_din[7:0])) err = 1;
          if (m_wide) begin
            q.push_back(bus_din[15:8]);
            if (bus_pin[1] != op(bus_din[15:8])) err = 1;
          end
        end
      end else begin
        bit rdy; rdy = q.size() < DEPTH;
        if (xf) repeat (nb) void'(q.pop_front());
        if (s_valid && rdy) q.push_back(s_data);
      end
      if (cfg_we && cfg_addr == 3) m_perr = 0;
      if (err) m_perr = 1;
      case (m_st)
        0: if (able && hs_in) begin
             if (m_waits == 0) m_st = 2; else begin m_st = 1; m_cnt = m_waits; end
           end
        1: if (m_cnt == 1) m_st = 2; else m_cnt--;
        2: m_st = 3;
        default: if (!hs_in) m_st = 0;
      endcase
      if (cfg_we) case (cfg_addr)
        0: m_pol = cfg_wdata;
        1: m_ae = cfg_wdata;
        2: m_af = cfg_wdata;
        default: begin m_slave = cfg_wdata[0]; m_wide = cfg_wdata[1]; m_waits = cfg_wdata[7:4]; end
      endcase
    end
  end

  // per-cycle comparison
  always begin : cmp
    int nb, sz; bit able, co, cs, drv, oe;
    logic [15:0] ed; logic [1:0] ep;
    @(posedge clk); #(SAMPLE_DLY);
    if (rst_n && chk_on) begin
      sz = q.size(); nb = m_wide ? 2 : 1;
      able = inbound ? (DEPTH - sz >= nb) : (sz >= nb);
      drv = (m_st == 1 || m_st == 2);
      cs = (m_st != 0);
      co = m_slave ? (m_st == 2 || m_st == 3) : ((m_st == 0 && able) || drv);
      oe = !inbound && drv;
      chk(m_valid == (inbound && sz > 0), "R1", "m_valid", m_valid, inbound && sz > 0);
      if (inbound && sz > 0) chk(m_data == q[0], "R2", "m_data", m_data, q[0]);
      chk(s_ready == (!inbound && sz < DEPTH), "R2", "s_ready", s_ready, !inbound && sz < DEPTH);
      chk(ctl_out == (co ^ m_pol[5]), m_slave ? "R8" : "R7", "ctl_out", ctl_out, co ^ m_pol[5]);
      chk(wr_o == ((m_slave && m_st == 2 && !inbound) ^ m_pol[4]), m_slave ? "R8" : "R7", "wr_o",
          wr_o, (m_slave && m_st == 2 && !inbound) ^ m_pol[4]);
      chk(rd_o == ((m_slave && m_st == 2 && inbound) ^ m_pol[3]), m_slave ? "R8" : "R7", "rd_o",
          rd_o, (m_slave && m_st == 2 && inbound) ^ m_pol[3]);
      chk(cs_o == (cs ^ m_pol[2]), "R11", "cs_o", cs_o, cs ^ m_pol[2]);
      chk(ae_o == ((sz <= m_ae) ^ m_pol[0]), "R5", "ae_o", ae_o, (sz <= m_ae) ^ m_pol[0]);
      chk(af_o == ((sz >= m_af) ^ m_pol[1]), "R5", "af_o", af_o, (sz >= m_af) ^ m_pol[1]);
      chk(par_err == m_perr, "R4", "par_err", par_err, m_perr);
      chk(bus_oe == oe, "R1", "bus_oe", bus_oe, oe);
      if (oe) begin
        ed = m_wide ? {q[1], q[0]} : {8'h00, q[0]};
        ep = {m_wide ? op(q[1]) : 1'b0, op(q[0])};
        chk(bus_dout == ed, "R9", "bus_dout", bus_dout, ed);
        chk(bus_pout == ep, "R3", "bus_pout", bus_pout, ep);
      end
    end
  end

  // stream drivers
  always @(negedge clk) begin
    s_valid <= ($urandom % 100) < s_prob;
    s_data  <= 8'($urandom);
    m_ready <= ($urandom % 100) < mr_prob;
  end

  // bus partner
  always @(negedge clk) begin : partner
    bit co; logic [15:0] w; logic [1:0] p;
    co = ctl_out ^ b_pol[5];
    if ((!b_slave && !hs_lvl && co && partner_on) || (b_slave && !hs_lvl && !co && partner_on)) begin
      w = 16'($urandom);
      p = {op(w[15:8]), op(w[7:0])};
      if (($urandom % 100) < inj_prob) begin
        if (inj_hi_only || ($urandom % 2)) p[1] = ~p[1]; else p[0] = ~p[0];
      end
      bus_din = w; bus_pin = p; hs_lvl = 1;
    end else if (hs_lvl && ((!b_slave && !co) || (b_slave && co))) begin
      hs_lvl = 0;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wcfg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    if (a == 0) b_pol = d;
    if (a == 3) begin b_slave = d[0]; b_wide = d[1]; end
  endtask

  task automatic quiet();
    partner_on = 0;
    cyc(2);
    for (int i = 0; i < 200 && !(m_st == 0 && !hs_lvl); i++) cyc(1);
  endtask

  task automatic drain();
    s_prob = 0; mr_prob = 100; inj_prob = 0;
    if (inbound) begin
      quiet();
      for (int i = 0; i < 200 && q.size() != 0; i++) cyc(1);
    end else begin
      partner_on = 1;
      for (int i = 0; i < 500 && q.size() >= (m_wide ? 2 : 1); i++) cyc(1);
      quiet();
      if (q.size() != 0) begin
        wcfg(3, {4'(m_waits), 2'b00, 1'b0, b_slave});
        partner_on = 1;
        for (int i = 0; i < 200 && q.size() != 0; i++) cyc(1);
        quiet();
      end
    end
  endtask

  task automatic meas_wait(input int w);
    int n; logic [15:0] wd;
    wd = 16'hBEEF;
    wcfg(3, {4'(w), 2'b00, 1'b1, 1'b0});
    mr_prob = 0; partner_on = 0; cyc(2);
    @(negedge clk);
    bus_din = wd; bus_pin = {op(wd[15:8]), op(wd[7:0])}; hs_lvl = 1;
    n = 0;
    for (int i = 0; i < 40; i++) begin
      @(posedge clk); #(SAMPLE_DLY);
      if (cs_o && ctl_out) n++;
      else if (cs_o && !ctl_out) break;
    end
    chk(n == w + 1, "R10", "cycles to transfer", n, w + 1);
    chk(m_valid && m_data == 8'hEF, "R9", "first byte low lane", m_data, 8'hEF);
    mr_prob = 100;
    @(posedge clk); #(SAMPLE_DLY);
    mr_prob = 0;
    chk(m_valid && m_data == 8'hBE, "R9", "second byte high lane", m_data, 8'hBE);
    drain();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    $display("FAIL watchdog expired total=%0d", total);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cyc(4);
    rst_n = 1;
    @(posedge clk); #(SAMPLE_DLY);
    // R12 reset state
    chk(par_err == 0, "R12", "par_err", par_err, 0);
    chk(ae_o == 1, "R12", "ae_o", ae_o, 1);
    chk(af_o == 0, "R12", "af_o", af_o, 0);
    chk(m_valid == 0, "R12", "m_valid", m_valid, 0);
    chk(ctl_out == 1, "R12", "request with empty fifo", ctl_out, 1);
    chk(cs_o == 0 && wr_o == 0 && rd_o == 0, "R12", "strobes", {cs_o, wr_o, rd_o}, 0);
    chk_on = 1;

    // inbound master, 8-bit, no waits
    partner_on = 1; mr_prob = 70; cyc(300); drain();
    // inbound master, 16-bit, 3 waits, new thresholds, heavy back-pressure
    wcfg(1, 8'd4); wcfg(2, 8'd12); wcfg(3, 8'h32);
    partner_on = 1; mr_prob = 20; cyc(400); drain();
    // parity faults, 16-bit
    inj_prob = 30; partner_on = 1; mr_prob = 60; cyc(300); drain();
    chk(par_err == 1, "R4", "error set by fault", par_err, 1);
    cyc(5);
    chk(par_err == 1, "R4", "error sticky", par_err, 1);
    wcfg(3, 8'h32);
    @(posedge clk); #(SAMPLE_DLY);
    chk(par_err == 0, "R4", "error cleared by write", par_err, 0);
    // 8-bit with upper-lane faults only: ignored
    wcfg(3, 8'h10);
    inj_prob = 50; inj_hi_only = 1; partner_on = 1; mr_prob = 60; cyc(200); drain();
    inj_hi_only = 0;
    chk(par_err == 0, "R4", "upper lane ignored in 8-bit", par_err, 0);
    // wait-count measurement
    meas_wait(5);
    meas_wait(0);
    // outbound master, 16-bit, 2 waits
    inbound = 0;
    wcfg(3, 8'h22);
    s_prob = 60; partner_on = 1; cyc(400); drain();
    // slave inbound 8-bit, 1 wait
    inbound = 1;
    wcfg(3, 8'h11);
    partner_on = 1; mr_prob = 50; cyc(300); drain();
    // slave outbound 16-bit, 0 waits
    inbound = 0;
    wcfg(3, 8'h03);
    s_prob = 70; partner_on = 1; cyc(300); drain();
    // all polarities inverted
    wcfg(3, 8'h00);
    wcfg(0, 8'hFF);
    cyc(2);
    @(posedge clk); #(SAMPLE_DLY);
    chk(ctl_out == 1, "R6", "inverted idle request", ctl_out, 1);
    chk(wr_o == 1 && rd_o == 1, "R6", "inverted strobes", {wr_o, rd_o}, 2'b11);
    chk(cs_o == 1, "R6", "inverted select", cs_o, 1);
    chk(ae_o == 0 && af_o == 1, "R6", "inverted flags", {ae_o, af_o}, 2'b01);
    inbound = 1;
    wcfg(3, 8'h23);
    partner_on = 1; mr_prob = 50; cyc(300); drain();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule